// File: doc/BRIEF.md
# Clock-Register Window Decoder for an SRAM Bus

This block sits on a host memory bus in front of an external static RAM. It lets every host access through to the RAM except those aimed at the sixteen highest locations of the 19-bit address space. Those locations are reserved for a bank of clock registers held in an internal register file. For addresses in that window, the decoder keeps the RAM deselected. It presents a 4-bit register index to the register file, raises a one-cycle write strobe when a write begins, and enables the data-bus drivers for reads.

All host signals are sampled on the block clock, and each output is registered once. Every output therefore reflects the inputs sampled at the same clock edge. Supply status and the power-on reset status override everything. While power is below the trip point, or while the reset output is still asserted, both RAM enables stay inactive, no strobe is issued and the data bus is left undriven. The block reset is asserted asynchronously and released through a synchronizer, so outputs keep their reset values for two clock edges after `rst_n` rises.

Top module: `rtc_window_decoder`

## Requirements
- R1: The register window is every address with bits 18..4 all ones (0x7FFF0 to 0x7FFFF). At an edge where the address is in the window and access is allowed, `reg_idx` loads address bits 3..0. At any other edge it holds its value.
- R2: Outside the window, with access allowed, `sram_ce_n` after an edge equals `host_ce_n` sampled at that edge.
- R3: Inside the window, `sram_ce_n` after the edge is 1 whatever `host_ce_n` is.
- R4: With access allowed, `sram_oe_n` after an edge equals `host_oe_n` sampled at that edge.
- R5: `dq_oe` is 1 after an edge exactly when, at that edge, access was allowed, the address was in the window, `host_ce_n`=0, `host_oe_n`=0 and `host_we_n`=1.
- R6: A register write condition is: access allowed, address in the window, `host_ce_n`=0 and `host_we_n`=0. No strobe is ever issued for an address outside the window.
- R7: Access is allowed only when `pwr_good`=1 and `por_n`=1. At an edge where it is not allowed, the outputs after that edge are `sram_ce_n`=1, `sram_oe_n`=1, `dq_oe`=0 and `reg_wr`=0.
- R8: When `host_we_n` and `host_oe_n` are both 0 during a register access, the write is taken and `dq_oe` stays 0.
- R9: `reg_wr` is 1 after an edge exactly when the write condition holds at that edge and did not hold at the previous edge. A write held for several cycles gives a single one-cycle pulse.
- R10: While reset is applied, and for two edges after its release, `sram_ce_n`=1, `sram_oe_n`=1, `dq_oe`=0, `reg_wr`=0 and `reg_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 19 | Host address |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| pwr_good | input | 1 | 1 while supply is above the trip point |
| por_n | input | 1 | 0 while the power-on reset output is asserted |
| sram_ce_n | output | 1 | Registered RAM chip enable, active low |
| sram_oe_n | output | 1 | Registered RAM output enable, active low |
| reg_idx | output | 4 | Register-file index |
| reg_wr | output | 1 | One-cycle register write strobe |
| dq_oe | output | 1 | Data-bus driver enable for register reads |

## Verification
The assertions assume that host inputs are stable around each rising clock edge and that the reset status and power status are plain levels that may change in any cycle. The bench therefore drives every input on the falling edge. It toggles `pwr_good` and `por_n` independently of the bus, including in the middle of held writes. The address stimulus is biased toward the window boundary, so accesses at 0x7FFEF and 0x7FFF0 occur under every enable combination.

// File: rtl/rtcdec_pkg.sv
package rtcdec_pkg;
  parameter int ADDR_W      = 19;
  parameter int IDX_W       = 4;
  parameter int SYNC_STAGES = 2;
  localparam int TAG_W      = ADDR_W - IDX_W;
endpackage

// File: rtl/rtcdec_rst_sync.sv
module rtcdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtcdec_match.sv
module rtcdec_match #(
  parameter int ADDR_W = 19,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx
);
  localparam int TAG_W = ADDR_W - IDX_W;
  logic [TAG_W-1:0] tag_hit;

  for (genvar b = 0; b < TAG_W; b++) begin : g_tag
    assign tag_hit[b] = addr[IDX_W + b];
  end

  assign in_win = &tag_hit;
  assign idx    = addr[IDX_W-1:0];
endmodule

// File: rtl/rtcdec_gate.sv
module rtcdec_gate #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             in_win,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             host_ce_n,
  input  logic             host_oe_n,
  input  logic             host_we_n,
  output logic             sram_ce_n,
  output logic             sram_oe_n,
  output logic             dq_oe,
  output logic [IDX_W-1:0] reg_idx
);
  logic             ce_d, oe_d, drv_d, idx_en;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    ce_d   = !allow || in_win || host_ce_n;
    oe_d   = !allow || host_oe_n;
    drv_d  = allow && in_win && !host_ce_n && !host_oe_n && host_we_n;
    idx_en = allow && in_win;
    idx_d  = idx_en ? idx_in : reg_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      dq_oe     <= 1'b0;
      reg_idx   <= '0;
    end else begin
      sram_ce_n <= ce_d;
      sram_oe_n <= oe_d;
      dq_oe     <= drv_d;
      reg_idx   <= idx_d;
    end
  end

  p_ce_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> $past(!in_win && allow && !host_ce_n));
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(allow) |-> (sram_ce_n && sram_oe_n && !dq_oe));
  p_drive_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> sram_ce_n);
  p_oe_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(allow)) |-> (sram_oe_n == $past(host_oe_n)));
endmodule

// File: rtl/rtcdec_strobe.sv
module rtcdec_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_cond,
  output logic reg_wr
);
  logic cond_q;
  logic wr_d;

  always_comb begin
    wr_d = wr_cond && !cond_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      reg_wr <= 1'b0;
    end else begin
      cond_q <= wr_cond;
      reg_wr <= wr_d;
    end
  end

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
endmodule

// File: rtl/rtc_window_decoder.sv
module rtc_window_decoder
  import rtcdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic              pwr_good,
  input  logic              por_n,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_wr,
  output logic              dq_oe
);
  logic             rst_i;
  logic             in_win;
  logic [IDX_W-1:0] idx_c;
  logic             allow;
  logic             wr_cond;

  rtcdec_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .rst_sync_n(rst_i)
  );

  rtcdec_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .addr(host_addr), .in_win(in_win), .idx(idx_c)
  );

  assign allow   = pwr_good && por_n;
  assign wr_cond = allow && in_win && !host_ce_n && !host_we_n;

  rtcdec_gate #(.IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_i), .allow(allow), .in_win(in_win),
    .idx_in(idx_c), .host_ce_n(host_ce_n), .host_oe_n(host_oe_n),
    .host_we_n(host_we_n), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .dq_oe(dq_oe), .reg_idx(reg_idx)
  );

  rtcdec_strobe u_strobe (
    .clk(clk), .rst_n(rst_i), .wr_cond(wr_cond), .reg_wr(reg_wr)
  );

  p_wr_nodrive_r8: assert property (@(posedge clk) disable iff (!rst_i)
    reg_wr |-> !dq_oe);
  p_wr_window_r6: assert property (@(posedge clk) disable iff (!rst_i)
    reg_wr |-> $past(in_win && allow));
endmodule

// File: tb/test_rtc_window_decoder.sv
`timescale 1ns/1ps
module test_rtc_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [18:0] host_addr;
  logic        host_ce_n, host_oe_n, host_we_n, pwr_good, por_n;
  logic        sram_ce_n, sram_oe_n, reg_wr, dq_oe;
  logic [3:0]  reg_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rtc_window_decoder i_rtc_window_decoder (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_ce_n(host_ce_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .pwr_good(pwr_good),
    .por_n(por_n), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .reg_idx(reg_idx), .reg_wr(reg_wr), .dq_oe(dq_oe)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated on every clock
  int edges_since_rel = 0;
  bit prev_wc = 0;
  int e_idx = 0;
  always @(posedge clk) begin
    bit win, al, wc, e_ce, e_oe, e_dq, e_wr, rdy;
    win = (host_addr >= 19'h7FFF0);
    al  = pwr_good && por_n;
    wc  = al && win && !host_ce_n && !host_we_n;
    if (!rst_n) edges_since_rel = 0; else edges_since_rel++;
    rdy = rst_n && edges_since_rel > 2;
    if (!rdy) begin
      e_ce = 1; e_oe = 1; e_dq = 0; e_wr = 0; e_idx = 0; prev_wc = 0;
    end else begin
      e_ce = !al || win || host_ce_n;
      e_oe = !al || host_oe_n;
      e_dq = al && win && !host_ce_n && !host_oe_n && host_we_n;
      e_wr = wc && !prev_wc;
      if (al && win) e_idx = int'(host_addr[3:0]);
      prev_wc = wc;
    end
    #1;
    if (!rdy) begin
      chk("R10 ce", sram_ce_n, e_ce); chk("R10 oe", sram_oe_n, e_oe);
      chk("R10 dq", dq_oe, e_dq);     chk("R10 wr", reg_wr, e_wr);
      chk("R10 idx", reg_idx, e_idx);
    end else begin
      chk(!al ? "R7 ce" : (win ? "R3 ce" : "R2 ce"), sram_ce_n, e_ce);
      chk(al ? "R4 oe" : "R7 oe", sram_oe_n, e_oe);
      chk(!al ? "R7 dq" : ((!host_we_n && !host_oe_n && win) ? "R8 dq" : "R5 dq"), dq_oe, e_dq);
      chk(!al ? "R7 wr" : (win ? "R9 wr" : "R6 wr"), reg_wr, e_wr);
      chk("R1 idx", reg_idx, e_idx);
    end
  end

  task automatic drive(logic [18:0] a, bit ce, bit oe, bit we, bit pg, bit pr);
    @(negedge clk);
    host_addr = a; host_ce_n = ce; host_oe_n = oe; host_we_n = we;
    pwr_good = pg; por_n = pr;
  endtask

  initial begin
    rst_n = 0; host_addr = '0; host_ce_n = 1; host_oe_n = 1; host_we_n = 1;
    pwr_good = 1; por_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 R2 R3 R5: read sweep across the window boundary
    for (int a = 'h7FFEC; a <= 'h7FFF3; a++) drive(19'(a), 0, 0, 1, 1, 1);
    for (int a = 'h7FFEE; a <= 'h7FFF1; a++) drive(19'(a), 1, 0, 1, 1, 1);
    // R9: held write gives one pulse
    repeat (4) drive(19'h7FFF5, 0, 1, 0, 1, 1);
    drive(19'h7FFF5, 1, 1, 1, 1, 1);
    // R8: write and read enables together
    repeat (2) drive(19'h7FFFA, 0, 0, 0, 1, 1);
    // R6: write outside window
    repeat (2) drive(19'h7FFEF, 0, 1, 0, 1, 1);
    // R7: power fail and reset status during accesses
    drive(19'h7FFF2, 0, 0, 1, 0, 1);
    drive(19'h00100, 0, 0, 1, 0, 1);
    drive(19'h7FFF3, 0, 1, 0, 1, 0);
    drive(19'h7FFF3, 0, 1, 0, 1, 1);
    drive(19'h7FFF3, 0, 1, 0, 0, 1);
    drive(19'h7FFF3, 0, 1, 0, 1, 1);
    // randomized, biased to the boundary
    for (int i = 0; i < 400; i++) begin
      logic [18:0] a;
      a = ($urandom % 2) ? 19'(19'h7FFE8 + ($urandom % 24)) : 19'($urandom);
      drive(a, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            ($urandom % 8) != 0, ($urandom % 8) != 0);
    end
    // R10: reset mid-run
    @(negedge clk); rst_n = 0; host_ce_n = 0; host_addr = 19'h7FFF1;
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule